// File: doc/BRIEF.md
# 32-Line GPIO Controller with Edge Interrupts

The block is a general-purpose I/O peripheral for 32 lines, reached over a simple 32-bit register bus with single-cycle access. Software sets each line as an input or an output. An output line can drive both levels, or only pull low (open-drain style). Input lines are synchronised into the clock domain. A per-line enable decides whether the pad value is visible in the data register.

Each line has an edge detector. A per-line mode bit selects either falling-edge-only detection or detection on both edges. A detected edge sets a sticky event bit, which software clears by writing a 1 to it. A per-line mask decides whether that event contributes to the single combined interrupt output. Every register keeps a fixed bit order in which line n sits at register bit 31−n. The pad ports are indexed by line number.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x00 direction, 0x04 open-drain select, 0x08 data, 0x0C event, 0x10 interrupt mask, 0x14 edge mode and 0x18 input enable. Direction, open-drain, mask, mode and input enable read back the value last written. A read of any other offset, and the read bus whenever `bus_rd` is low, return 0. A read returns the value held before a write in the same cycle.
- R2: Line n is register bit 31−n in every register. Pad port bit n is line n.
- R3: After reset every register reads 0, `pad_oe` is all 0 and `irq_out` is 0.
- R4: A data read returns the output latch for lines whose direction bit is 1. For input lines it returns the synchronised pad value when the line's input-enable bit is 1, and 0 otherwise. Writing the data offset loads the output latch for all lines.
- R5: A pad value driven before clock edge k is first visible in data reads after edge k+1 (two-flop synchroniser).
- R6: Edge detection compares the synchronised value with its value one cycle earlier. Mode bit 1 sets the event only on a falling edge; mode bit 0 sets it on both edges. The event bit is set at the clock edge after the synchronised value changes. Detection runs whatever the line's direction and input enable.
- R7: Writing the event offset clears each event bit written as 1. Bits written as 0 are unchanged.
- R8: An edge detected in the same cycle as a clearing write to that bit leaves the event bit set.
- R9: `irq_out` is 1 exactly when some line has both its event bit and its mask bit at 1. A masked-off line still records events.
- R10: A direction-0 line has `pad_oe` 0. With open-drain 0, an output line has `pad_oe` 1 and `pad_out` equal to the latch. With open-drain 1, `pad_out` is 0 and `pad_oe` is the inverse of the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data, register bit order |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational, register bit order |
| pad_in | input | 32 | Pad input levels, bit n is line n |
| pad_out | output | 32 | Pad output levels, bit n is line n |
| pad_oe | output | 32 | Pad output enables, bit n is line n |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A wrong bit of internal state shows at the ports quickly. A corrupted direction, open-drain or latch bit changes `pad_oe` or `pad_out` in the same cycle. A lost or spurious event bit changes `irq_out` as soon as that line is unmasked, and shows in the next event-register read. A synchroniser stage that is too short or too long moves the data-read change and the event change by one clock. The bench compares all three outputs, and every read, against a behavioural model on every clock, so any such skew is reported in the first cycle where it differs.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

    parameter int GPIO_LINES = 32;

    typedef logic [GPIO_LINES-1:0] line_vec_t;

    // all vectors held in line order: bit n = line n
    typedef struct packed {
        line_vec_t dir;
        line_vec_t odrn;
        line_vec_t latch;
        line_vec_t evt;
        line_vec_t msk;
        line_vec_t mode;
        line_vec_t inen;
    } gpio_regs_t;

    localparam int OFS_DIR   = 'h00;
    localparam int OFS_ODRN  = 'h04;
    localparam int OFS_DATA  = 'h08;
    localparam int OFS_EVT   = 'h0C;
    localparam int OFS_MSK   = 'h10;
    localparam int OFS_MODE  = 'h14;
    localparam int OFS_INEN  = 'h18;

    // register bit order <-> line order (self-inverse)
    function automatic line_vec_t swap_order(input line_vec_t v);
        line_vec_t r;
        for (int i = 0; i < GPIO_LINES; i++) begin
            r[i] = v[GPIO_LINES-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge
    import gpio_ctrl_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  line_vec_t pad_in,
    input  line_vec_t mode,
    output line_vec_t synced,
    output line_vec_t hit
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][GPIO_LINES-1:0] chain;
        line_vec_t                         prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = pad_in;
        for (int k = 1; k < STAGES; k++) begin
            st_d.chain[k] = st_q.chain[k-1];
        end
        st_d.prev = st_q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign synced = st_q.chain[LAST];

    // falling: prev 1 -> now 0; rising counts only in both-edge mode
    assign hit = (st_q.prev & ~synced) | (~mode & ~st_q.prev & synced);

    // a line in falling-only mode never reports a hit while its level is high
    assert_falling_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode & hit & synced) == '0));

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_ctrl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [GPIO_LINES-1:0] bus_wdata,
    input  logic                  bus_rd,
    output logic [GPIO_LINES-1:0] bus_rdata,
    input  line_vec_t             synced,
    input  line_vec_t             hit,
    output gpio_regs_t            regs
);

    gpio_regs_t regs_d, regs_q;
    line_vec_t  wr_lines;
    line_vec_t  clr_d;
    line_vec_t  view_d;
    line_vec_t  rd_lines;
    logic sel_dir, sel_odrn, sel_data, sel_evt, sel_msk, sel_mode, sel_inen;

    always_comb begin
        sel_dir  = (bus_addr == ADDR_W'(OFS_DIR));
        sel_odrn = (bus_addr == ADDR_W'(OFS_ODRN));
        sel_data = (bus_addr == ADDR_W'(OFS_DATA));
        sel_evt  = (bus_addr == ADDR_W'(OFS_EVT));
        sel_msk  = (bus_addr == ADDR_W'(OFS_MSK));
        sel_mode = (bus_addr == ADDR_W'(OFS_MODE));
        sel_inen = (bus_addr == ADDR_W'(OFS_INEN));
    end

    // next-state
    always_comb begin
        regs_d   = regs_q;
        wr_lines = swap_order(bus_wdata);
        clr_d    = (bus_wr && sel_evt) ? wr_lines : '0;
        // new edge beats a clear in the same cycle
        regs_d.evt = (regs_q.evt & ~clr_d) | hit;
        if (bus_wr) begin
            if (sel_dir)  regs_d.dir   = wr_lines;
            if (sel_odrn) regs_d.odrn  = wr_lines;
            if (sel_data) regs_d.latch = wr_lines;
            if (sel_msk)  regs_d.msk   = wr_lines;
            if (sel_mode) regs_d.mode  = wr_lines;
            if (sel_inen) regs_d.inen  = wr_lines;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // read path
    always_comb begin
        view_d   = (regs_q.dir & regs_q.latch) | (~regs_q.dir & regs_q.inen & synced);
        rd_lines = '0;
        if (sel_dir)  rd_lines = regs_q.dir;
        if (sel_odrn) rd_lines = regs_q.odrn;
        if (sel_data) rd_lines = view_d;
        if (sel_evt)  rd_lines = regs_q.evt;
        if (sel_msk)  rd_lines = regs_q.msk;
        if (sel_mode) rd_lines = regs_q.mode;
        if (sel_inen) rd_lines = regs_q.inen;
        bus_rdata = bus_rd ? swap_order(rd_lines) : '0;
    end

    assign regs = regs_q;

    assert_reset_clear_R3: assert property (@(posedge clk)
        !rst_n |=> (regs_q == '0));

    assert_clear_only_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(regs_q.evt) & ~regs_q.evt) & ~$past(clr_d)) == '0));

    assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(hit) & ~regs_q.evt) == '0));

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_ctrl_pkg::*;
(
    input  line_vec_t dir,
    input  line_vec_t odrn,
    input  line_vec_t latch,
    output line_vec_t pad_out,
    output line_vec_t pad_oe
);

    for (genvar i = 0; i < GPIO_LINES; i++) begin : g_line
        // open-drain: drive low only, release when latch is 1
        assign pad_out[i] = latch[i] & ~odrn[i];
        assign pad_oe[i]  = dir[i] & ~(odrn[i] & latch[i]);
    end

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [GPIO_LINES-1:0] bus_wdata,
    input  logic                  bus_rd,
    output logic [GPIO_LINES-1:0] bus_rdata,
    input  logic [GPIO_LINES-1:0] pad_in,
    output logic [GPIO_LINES-1:0] pad_out,
    output logic [GPIO_LINES-1:0] pad_oe,
    output logic                  irq_out
);

    gpio_regs_t regs;
    line_vec_t  synced;
    line_vec_t  hit;

    gpio_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .mode   (regs.mode),
        .synced (synced),
        .hit    (hit)
    );

    gpio_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .synced    (synced),
        .hit       (hit),
        .regs      (regs)
    );

    gpio_pad_drive u_pads (
        .dir     (regs.dir),
        .odrn    (regs.odrn),
        .latch   (regs.latch),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign irq_out = |(regs.evt & regs.msk);

    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.msk == '0) |-> !irq_out);

    assert_input_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((~regs.dir & pad_oe) == '0));

    assert_od_never_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs.odrn & pad_out) == '0));

endmodule

// File: tb/gpio_edge_ctrl_test.sv
module gpio_edge_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    gpio_edge_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
    );

    // behavioural model, line order (index n = line n)
    logic [31:0] m_dir, m_od, m_lat, m_evt, m_msk, m_mode, m_inen;
    logic [31:0] hist[$];   // [0] newest pad sample, [1] synced, [2] one earlier

    function automatic logic [31:0] flip(input logic [31:0] v);
        logic [31:0] r;
        for (int n = 0; n < 32; n++) r[31-n] = v[n];
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dir = 0; m_od = 0; m_lat = 0; m_evt = 0; m_msk = 0; m_mode = 0; m_inen = 0;
            hist = '{32'h0, 32'h0, 32'h0};
        end else begin
            logic [31:0] w, clr;
            w = flip(bus_wdata);
            clr = (bus_wr && bus_addr == 8'h0C) ? w : 32'h0;
            for (int n = 0; n < 32; n++) begin
                bit now_v, was_v, edge_seen;
                now_v = hist[1][n];
                was_v = hist[2][n];
                edge_seen = (was_v && !now_v) || (!m_mode[n] && !was_v && now_v);
                if (clr[n]) m_evt[n] = 1'b0;
                if (edge_seen) m_evt[n] = 1'b1;
            end
            if (bus_wr) begin
                case (bus_addr)
                    8'h00: m_dir  = w;
                    8'h04: m_od   = w;
                    8'h08: m_lat  = w;
                    8'h10: m_msk  = w;
                    8'h14: m_mode = w;
                    8'h18: m_inen = w;
                    default: ;
                endcase
            end
            hist.push_front(pad_in);
            void'(hist.pop_back());
        end
    end

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        logic [31:0] v;
        v = 0;
        case (a)
            8'h00: v = m_dir;
            8'h04: v = m_od;
            8'h08: for (int n = 0; n < 32; n++)
                       v[n] = m_dir[n] ? m_lat[n] : (m_inen[n] & hist[1][n]);
            8'h0C: v = m_evt;
            8'h10: v = m_msk;
            8'h14: v = m_mode;
            8'h18: v = m_inen;
            default: v = 0;
        endcase
        return flip(v);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (rst_n && !finished) begin
            logic [31:0] e_oe, e_out;
            for (int n = 0; n < 32; n++) begin
                e_oe[n]  = m_dir[n] && !(m_od[n] && m_lat[n]);
                e_out[n] = m_lat[n] && !m_od[n];
            end
            chk("R10 pad_oe", pad_oe, e_oe);
            chk("R10 pad_out", pad_out, e_out);
            chk("R9 irq_out", {31'h0, irq_out}, {31'h0, |(m_evt & m_msk)});
            if (bus_rd) begin
                case (bus_addr)
                    8'h08:   chk("R4 data read", bus_rdata, exp_read(bus_addr));
                    8'h0C:   chk("R6 event read", bus_rdata, exp_read(bus_addr));
                    default: chk("R1 register read", bus_rdata, exp_read(bus_addr));
                endcase
            end else begin
                chk("R1 idle read bus", bus_rdata, 32'h0);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a; bus_rd = 1'b1;
        #3;
        chk(tag, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual hung expected done");
        finished = 1;
        summary();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // R3: reset state
        rd_chk("R3 dir reset", 8'h00, 0);
        rd_chk("R3 odrn reset", 8'h04, 0);
        rd_chk("R3 data reset", 8'h08, 0);
        rd_chk("R3 event reset", 8'h0C, 0);
        rd_chk("R3 mask reset", 8'h10, 0);
        rd_chk("R3 mode reset", 8'h14, 0);
        rd_chk("R3 inen reset", 8'h18, 0);
        chk("R3 pad_oe reset", pad_oe, 0);
        chk("R3 irq reset", {31'h0, irq_out}, 0);

        // R1: readback and undefined offsets
        wr(8'h00, 32'h1234_5678); rd_chk("R1 dir readback", 8'h00, 32'h1234_5678);
        wr(8'h04, 32'hA5A5_0F0F); rd_chk("R1 odrn readback", 8'h04, 32'hA5A5_0F0F);
        wr(8'h10, 32'h0000_FFFF); rd_chk("R1 mask readback", 8'h10, 32'h0000_FFFF);
        wr(8'h14, 32'hF0F0_F0F0); rd_chk("R1 mode readback", 8'h14, 32'hF0F0_F0F0);
        wr(8'h18, 32'h3C3C_C3C3); rd_chk("R1 inen readback", 8'h18, 32'h3C3C_C3C3);
        rd_chk("R1 undefined 0x1C", 8'h1C, 0);
        rd_chk("R1 undefined 0x02", 8'h02, 0);
        rd_chk("R1 undefined 0x40", 8'h40, 0);
        wr(8'h00, 0); wr(8'h04, 0); wr(8'h10, 0); wr(8'h14, 0); wr(8'h18, 0);
        wr(8'h0C, 32'hFFFF_FFFF);

        // R2: line 0 is register bit 31, pad bit 0
        wr(8'h00, 32'h8000_0000);
        chk("R2 line0 oe", pad_oe, 32'h0000_0001);
        wr(8'h08, 32'h8000_0000);
        chk("R2 line0 out", pad_out, 32'h0000_0001);
        rd_chk("R4 output latch read", 8'h08, 32'h8000_0000);

        // R10: open-drain
        wr(8'h04, 32'h8000_0000);
        chk("R10 od latch1 released", pad_oe, 0);
        chk("R10 od latch1 out low", pad_out, 0);
        wr(8'h08, 0);
        chk("R10 od latch0 driven", pad_oe, 32'h0000_0001);
        chk("R10 od latch0 out low", pad_out, 0);
        wr(8'h04, 0); wr(8'h00, 0);

        // R4: input enable gating (line 31 = register bit 0)
        pad_in = 32'h8000_0000;
        step(4);
        rd_chk("R4 input gated off", 8'h08, 0);
        wr(8'h18, 32'hFFFF_FFFF);
        rd_chk("R4 input enabled", 8'h08, 32'h0000_0001);
        rd_chk("R6 rising edge both-mode", 8'h0C, 32'h0000_0001);

        // R7: write-1-to-clear
        wr(8'h0C, 0);
        rd_chk("R7 zero write keeps", 8'h0C, 32'h0000_0001);
        wr(8'h0C, 32'h0000_0001);
        rd_chk("R7 one write clears", 8'h0C, 0);

        // R5: synchroniser latency (line 30 = register bit 1)
        pad_in[30] = 1'b1;
        step(1);
        rd_chk("R5 not yet after one edge", 8'h08, 32'h0000_0001);
        rd_chk("R5 visible after two edges", 8'h08, 32'h0000_0003);
        rd_chk("R6 event one edge later", 8'h0C, 32'h0000_0002);

        // R6: falling-only mode on line 31
        wr(8'h14, 32'h0000_0001);
        wr(8'h0C, 32'hFFFF_FFFF);
        pad_in[31] = 1'b0;
        step(4);
        rd_chk("R6 falling sets", 8'h0C, 32'h0000_0001);
        wr(8'h0C, 32'hFFFF_FFFF);
        pad_in[31] = 1'b1;
        step(4);
        rd_chk("R6 rising ignored", 8'h0C, 0);

        // R8: edge and clear land on the same clock
        pad_in[30] = 1'b0;
        step(2);
        wr(8'h0C, 32'h0000_0002);
        rd_chk("R8 edge beats clear", 8'h0C, 32'h0000_0002);

        // R9: mask and combined interrupt
        chk("R9 masked no irq", {31'h0, irq_out}, 0);
        wr(8'h10, 32'h0000_0002);
        chk("R9 unmasked irq", {31'h0, irq_out}, 1);
        wr(8'h10, 32'h0000_0001);
        chk("R9 other line irq", {31'h0, irq_out}, 0);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF);
        chk("R9 cleared no irq", {31'h0, irq_out}, 0);

        // random traffic compared against the model every clock
        for (int i = 0; i < 600; i++) begin
            int pick;
            pad_in = $urandom;
            pick = $urandom_range(0, 7);
            bus_addr = 8'(pick * 4);
            bus_wdata = $urandom;
            bus_wr = ($urandom_range(0, 3) == 0);
            bus_rd = ($urandom_range(0, 1) == 0);
            @(negedge clk);
        end
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        step(2);
        finished = 1;
        summary();
    end

endmodule